// File: doc/BRIEF.md
# Interval Timer with Delayed Control

A 16-bit down-counting interval timer for a peripheral controller. Software writes a 16-bit reload value as two bytes and an 8-bit control byte through a byte-wide write port. The timer counts either on every enabled clock cycle or on an external strobe: a pin strobe, or the underflow strobe of a sibling timer when cascading is built in. Each underflow reloads the counter and produces a one-cycle interrupt pulse and a one-cycle underflow strobe. The underflow strobe can drive the cascade input of a second instance. A port bit can carry either the interrupt pulse or a level that toggles on each underflow.

A control write does not act at once. It is held for one cycle, then a seven-state sequencer applies it. Starting, restarting or force-loading the timer always inserts a wait cycle before counting resumes. Stopping a running timer without a force load lets it count once more. All state advances only on cycles where `tick_i` is high. A bus decoder and an interrupt controller sit outside the block.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter reads 0xFFFF, the reload value is 1, the control byte reads 0x00, and irq_o, underflow_o and port_en_o are low.
- R2: A write to address 0 sets the reload low byte and leaves the counter unchanged. A write to address 1 sets the reload high byte. It also copies the whole reload value into the counter in the same cycle, but only if control bit 0 (start) is clear.
- R3: A write to address 2 appears on ctrl_o one enabled cycle after the write cycle. Control bit 4 (force load) always reads back as 0.
- R4: Starting a stopped timer with reload value L ≥ 1 (control 0x01) gives the first underflow pulse L+2 cycles after the write cycle, because of one wait cycle. Starting sets the toggle level to 1.
- R5: In continuous mode the counter reloads on underflow. irq_o and underflow_o pulse for one cycle, and pulses recur every L+1 cycles (every 2 cycles for L=0).
- R6: With control bit 3 (one-shot) set, an underflow clears control bit 0, reloads the counter and stops it. No further pulse follows.
- R7: Writing control bit 0 = 0 to a running timer without force load lets it decrement in the write cycle, in the delay cycle and in one more cycle, then hold.
- R8: Force load (bit 4) with start clear reloads and stops the timer. With start set on a running timer it reloads, waits one cycle, then counts. If the counter holds 1 when the reload step of a start-with-force-load is reached, an underflow pulse is issued instead.
- R9: With control bit 1 set, port_en_o is high and port_o shows the toggle level when bit 2 is 1, or the interrupt pulse when bit 2 is 0.
- R10: Control bits 6:5 choose the count source: 00 every cycle, 01 ext_cnt_i strobes, 10 cascade_i strobes, 11 both strobes together. Without cascading built in, only bit 5 is decoded.
- R11: While tick_i is low, the counter, control byte and outputs hold, and writes are ignored.
- R12: If a stop write takes effect in the same cycle as an underflow, the underflow pulse is still issued, the counter reloads, and the timer stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Per-cycle enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 reload low, 1 reload high, 2 control |
| wr_data_i | input | 8 | Write data |
| ext_cnt_i | input | 1 | External pin count strobe |
| cascade_i | input | 1 | Sibling timer underflow strobe |
| count_o | output | 16 | Current counter value |
| ctrl_o | output | 8 | Control byte readback |
| underflow_o | output | 1 | One-cycle underflow strobe |
| irq_o | output | 1 | One-cycle interrupt pulse |
| port_o | output | 1 | Port bit value |
| port_en_o | output | 1 | Port bit drive enable |

## Verification
The sharpest collision is a delayed stop write being applied on the same cycle as an underflow. The bench polls the counter until it reads 2 and then writes control 0x00, so the write's delay cycle lands on the count from 1. It expects a pulse, a reloaded counter, a cleared start bit and silence afterwards. A second overlap is a start with force load applied while the counter already holds 1; the bench expects the reload step to turn into an underflow pulse.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CNT_W  = 16;
  localparam int CTRL_W = 8;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int B_START = 0;
  localparam int B_PORT  = 1;
  localparam int B_TGL   = 2;
  localparam int B_ONE   = 3;
  localparam int B_LOAD  = 4;
  localparam int B_SRC0  = 5;
  localparam int B_SRC1  = 6;

  typedef enum logic [2:0] {
    ST_STOP,
    ST_WAIT,
    ST_LD_STOP,
    ST_LD_CNT,
    ST_LD_WAIT,
    ST_CNT,
    ST_CNT_STOP
  } seq_e;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [CTRL_W-1:0] upd_i,
  input  logic              os_clr_i,
  output logic [CNT_W-1:0]  latch_nxt_o,
  output logic              hi_wr_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              pend_o,
  output logic [CTRL_W-1:0] pend_val_o
);
  logic [CNT_W-1:0]  latch_q;
  logic [CTRL_W-1:0] ctrl_q, pend_val_q;
  logic              pend_q;
  logic              wr_lo, wr_hi, wr_ctrl;

  assign wr_lo   = tick_i & wr_en_i & (wr_addr_i == ADDR_LO);
  assign wr_hi   = tick_i & wr_en_i & (wr_addr_i == ADDR_HI);
  assign wr_ctrl = tick_i & wr_en_i & (wr_addr_i == ADDR_CTRL);

  always_comb begin
    latch_nxt_o = latch_q;
    if (wr_lo) latch_nxt_o[7:0] = wr_data_i;
    if (wr_hi) latch_nxt_o[CNT_W-1:8] = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q    <= CNT_W'(1);
      ctrl_q     <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (tick_i) begin
      latch_q <= latch_nxt_o;
      pend_q  <= wr_ctrl;
      if (wr_ctrl) pend_val_q <= wr_data_i;
      // pending byte is consumed on the cycle after the write
      if (pend_q)        ctrl_q <= upd_i;
      else if (os_clr_i) ctrl_q[B_START] <= 1'b0;
    end
  end

  assign hi_wr_o    = wr_hi;
  assign ctrl_o     = ctrl_q;
  assign pend_o     = pend_q;
  assign pend_val_o = pend_val_q;

  // R3
  ctrl_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wr_ctrl && !pend_q) |=> ((ctrl_q | 8'h01) == ($past(ctrl_q) | 8'h01)));
  // R6
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && os_clr_i) |=> !ctrl_q[B_START]);
endmodule

// File: rtl/itmr_core.sv
module itmr_core
  import itmr_pkg::*;
#(
  parameter bit CASCADE_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ext_cnt_i,
  input  logic              cascade_i,
  input  logic [CNT_W-1:0]  latch_nxt_i,
  input  logic              hi_wr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              pend_i,
  input  logic [CTRL_W-1:0] pend_val_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CTRL_W-1:0] ctrl_upd_o,
  output logic              os_clr_o,
  output logic              ev_int_o,
  output logic              ev_uf_o,
  output logic              tgl_o
);
  seq_e             st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             tgl_q, tgl_n;
  logic             src_hit, do_cnt;
  logic [CTRL_W-1:0] nv;

  if (CASCADE_EN) begin : g_src_casc
    always_comb begin
      unique case (ctrl_i[B_SRC1:B_SRC0])
        2'b00:   src_hit = 1'b1;
        2'b01:   src_hit = ext_cnt_i;
        2'b10:   src_hit = cascade_i;
        default: src_hit = cascade_i & ext_cnt_i;
      endcase
    end
  end else begin : g_src_pin
    assign src_hit = ctrl_i[B_SRC0] ? ext_cnt_i : 1'b1;
  end

  always_comb begin
    st_n     = st_q;
    tgl_n    = tgl_q;
    cnt_n    = (hi_wr_i && !ctrl_i[B_START]) ? latch_nxt_i : cnt_q;
    ev_int_o = 1'b0;
    ev_uf_o  = 1'b0;
    os_clr_o = 1'b0;
    do_cnt   = 1'b0;

    unique case (st_q)
      ST_WAIT:     st_n = ST_CNT;
      ST_LD_STOP:  begin st_n = ST_STOP; cnt_n = latch_nxt_i; end
      ST_LD_CNT:   begin st_n = ST_CNT;  cnt_n = latch_nxt_i; end
      ST_LD_WAIT: begin
        st_n = ST_WAIT;
        if (cnt_n == CNT_W'(1)) ev_int_o = 1'b1;
        else                    cnt_n = latch_nxt_i;
      end
      ST_CNT:      do_cnt = 1'b1;
      ST_CNT_STOP: begin st_n = ST_STOP; do_cnt = 1'b1; end
      default: ;
    endcase

    if (do_cnt && src_hit) begin
      if (cnt_n <= CNT_W'(1)) begin
        ev_uf_o = 1'b1;
        cnt_n   = '0;
        if (st_q == ST_CNT) ev_int_o = 1'b1;
      end else begin
        cnt_n = cnt_n - CNT_W'(1);
      end
    end

    if (ev_int_o) begin
      cnt_n = latch_nxt_i;
      tgl_n = ~tgl_q;
      if (ctrl_i[B_ONE]) begin
        os_clr_o = 1'b1;
        st_n     = ST_LD_STOP;
      end else begin
        st_n = ST_LD_CNT;
      end
    end

    // delayed control byte, applied after the counting step
    nv = pend_val_i;
    if (os_clr_o) nv[B_START] = 1'b0;
    if (pend_i) begin
      unique case (st_n)
        ST_STOP, ST_LD_STOP: begin
          if (nv[B_START]) begin
            tgl_n = 1'b1;
            st_n  = nv[B_LOAD] ? ST_LD_WAIT : ST_WAIT;
          end else if (nv[B_LOAD]) begin
            st_n = ST_LD_STOP;
          end
        end
        ST_CNT: begin
          if (nv[B_START]) begin
            if (nv[B_LOAD]) st_n = ST_LD_WAIT;
          end else begin
            st_n = nv[B_LOAD] ? ST_LD_STOP : ST_CNT_STOP;
          end
        end
        ST_LD_CNT, ST_WAIT: begin
          if (!nv[B_START])    st_n = ST_STOP;
          else if (nv[B_LOAD]) st_n = ST_LD_WAIT;
        end
        default: ;
      endcase
    end
    ctrl_upd_o         = nv;
    ctrl_upd_o[B_LOAD] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_STOP;
      cnt_q <= '1;
      tgl_q <= 1'b0;
    end else if (tick_i) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      tgl_q <= tgl_n;
    end
  end

  assign count_o = cnt_q;
  assign tgl_o   = tgl_q;

  // R11
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/itmr_out.sv
module itmr_out
  import itmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ev_int_i,
  input  logic              ev_uf_i,
  input  logic              tgl_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              irq_o,
  output logic              underflow_o,
  output logic              port_o,
  output logic              port_en_o
);
  logic irq_q, uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      uf_q  <= 1'b0;
    end else if (tick_i) begin
      irq_q <= ev_int_i;
      uf_q  <= ev_int_i | ev_uf_i;
    end
  end

  assign irq_o       = irq_q;
  assign underflow_o = uf_q;
  assign port_en_o   = ctrl_i[B_PORT];
  assign port_o      = ctrl_i[B_TGL] ? tgl_i : irq_q;

  // R5
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && tick_i) |=> !irq_q);
  // R5
  irq_uf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> uf_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter bit CASCADE_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        ext_cnt_i,
  input  logic        cascade_i,
  output logic [15:0] count_o,
  output logic [7:0]  ctrl_o,
  output logic        underflow_o,
  output logic        irq_o,
  output logic        port_o,
  output logic        port_en_o
);
  logic [CNT_W-1:0]  latch_nxt;
  logic              hi_wr, pend, os_clr, ev_int, ev_uf, tgl;
  logic [CTRL_W-1:0] ctrl, pend_val, ctrl_upd;

  itmr_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .upd_i       (ctrl_upd),
    .os_clr_i    (os_clr),
    .latch_nxt_o (latch_nxt),
    .hi_wr_o     (hi_wr),
    .ctrl_o      (ctrl),
    .pend_o      (pend),
    .pend_val_o  (pend_val)
  );

  itmr_core #(.CASCADE_EN(CASCADE_EN)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .ext_cnt_i   (ext_cnt_i),
    .cascade_i   (cascade_i),
    .latch_nxt_i (latch_nxt),
    .hi_wr_i     (hi_wr),
    .ctrl_i      (ctrl),
    .pend_i      (pend),
    .pend_val_i  (pend_val),
    .count_o     (count_o),
    .ctrl_upd_o  (ctrl_upd),
    .os_clr_o    (os_clr),
    .ev_int_o    (ev_int),
    .ev_uf_o     (ev_uf),
    .tgl_o       (tgl)
  );

  itmr_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .ev_int_i    (ev_int),
    .ev_uf_i     (ev_uf),
    .tgl_i       (tgl),
    .ctrl_i      (ctrl),
    .irq_o       (irq_o),
    .underflow_o (underflow_o),
    .port_o      (port_o),
    .port_en_o   (port_en_o)
  );

  assign ctrl_o = ctrl;
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [7:0]  wr_data_i = 8'h00;
  logic        ext_cnt_i = 1'b0;
  logic        cascade_i = 1'b0;
  logic [15:0] count_o;
  logic [7:0]  ctrl_o;
  logic        underflow_o, irq_o, port_o, port_en_o;

  int errors = 0;
  int checks = 0;

  localparam int N_VEC = 5;
  localparam logic [15:0] V_LAT   [N_VEC] = '{16'd0, 16'd1, 16'd3, 16'd5, 16'd10};
  localparam int          V_FIRST [N_VEC] = '{3, 3, 5, 7, 12};
  localparam int          V_PER   [N_VEC] = '{2, 2, 4, 6, 11};

  always #10 clk = ~clk;

  interval_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ext_cnt_i(ext_cnt_i),
    .cascade_i(cascade_i), .count_o(count_o), .ctrl_o(ctrl_o),
    .underflow_o(underflow_o), .irq_o(irq_o), .port_o(port_o), .port_en_o(port_en_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq_o && n < 200);
  endtask

  task automatic halt_and_load(input logic [15:0] v);
    wr(2'd2, 8'h10);
    step(3);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, x, irqs;
    step(2);
    rst_ni = 1'b1;
    step(1);
    // R1
    chk("R1 count", count_o, 16'hFFFF);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 irq/uf/port_en", {irq_o, underflow_o, port_en_o}, 0);

    // R2
    wr(2'd0, 8'h03);
    chk("R2 low write keeps counter", count_o, 16'hFFFF);
    wr(2'd1, 8'h00);
    chk("R2 high write loads counter", count_o, 3);

    // R3, R4, R5
    wr(2'd2, 8'h01);
    chk("R3 ctrl not yet visible", ctrl_o, 0);
    step(1);
    chk("R3 ctrl visible after delay", ctrl_o, 1);
    step(1);
    chk("R4 wait cycle holds count", count_o, 3);
    step(1);
    chk("R4 first decrement", count_o, 2);
    step(2);
    chk("R4 first underflow at L+2", {irq_o, underflow_o}, 2'b11);
    chk("R5 reload on underflow", count_o, 3);
    step(1);
    chk("R5 pulse lasts one cycle", {irq_o, underflow_o}, 2'b00);
    step(3);
    chk("R5 period L+1", irq_o, 1);

    // R5 vector table
    for (int v = 0; v < N_VEC; v++) begin
      halt_and_load(V_LAT[v]);
      wr(2'd2, 8'h01);
      wait_irq(n);
      chk($sformatf("R4 first pulse L=%0d", V_LAT[v]), n, V_FIRST[v]);
      wait_irq(n);
      chk($sformatf("R5 period L=%0d", V_LAT[v]), n, V_PER[v]);
    end

    // R9 toggle mode
    halt_and_load(16'd3);
    wr(2'd2, 8'h07);
    step(1);
    chk("R9 port enabled, toggle set by start (R4)", {port_en_o, port_o}, 2'b11);
    step(4);
    chk("R9 toggle inverts on underflow", {irq_o, port_o}, 2'b10);
    step(4);
    chk("R9 toggle inverts again", port_o, 1);
    // R9 pulse mode
    wr(2'd2, 8'h03);
    step(1);
    chk("R9 pulse mode idle", port_o, 0);
    step(2);
    chk("R9 pulse mode follows irq", {irq_o, port_o}, 2'b11);
    step(1);
    chk("R9 pulse mode clears", port_o, 0);

    // R6 one-shot
    halt_and_load(16'd2);
    wr(2'd2, 8'h09);
    step(4);
    chk("R6 one-shot pulse", irq_o, 1);
    chk("R6 start bit cleared", ctrl_o, 8'h08);
    irqs = 0;
    for (int i = 0; i < 10; i++) begin step(1); if (irq_o) irqs++; end
    chk("R6 no further pulse", irqs, 0);
    chk("R6 counter reloaded and held", count_o, 2);

    // R7 stop without force load
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    step(10);
    x = count_o;
    wr(2'd2, 8'h00);
    step(5);
    chk("R7 three more decrements", count_o, x - 3);
    chk("R7 ctrl stopped", ctrl_o, 0);

    // R8 stop with force load
    wr(2'd2, 8'h01);
    step(10);
    wr(2'd2, 8'h10);
    step(2);
    chk("R8 force load while stopping", count_o, 16'h0100);
    step(3);
    chk("R8 held after reload", count_o, 16'h0100);
    // R8 force load while running
    wr(2'd2, 8'h01);
    step(10);
    wr(2'd2, 8'h11);
    step(2);
    chk("R8 reload while running", count_o, 16'h0100);
    step(2);
    chk("R8 wait then count", count_o, 16'h00FF);
    // R2 high write while running
    x = count_o;
    wr(2'd1, 8'h02);
    chk("R2 running high write no load", count_o, x - 1);
    // R8 force load with counter at 1
    halt_and_load(16'd1);
    wr(2'd0, 8'h05);
    chk("R2 low write keeps counter at 1", count_o, 1);
    wr(2'd2, 8'h11);
    step(2);
    chk("R8 load step with counter 1 pulses", irq_o, 1);
    chk("R8 counter reloaded", count_o, 5);

    // R12 stop applied on underflow cycle
    halt_and_load(16'd4);
    wr(2'd2, 8'h01);
    n = 0;
    while (count_o != 16'd2 && n < 50) begin @(negedge clk); n++; end
    wr(2'd2, 8'h00);
    step(1);
    chk("R12 pulse on colliding cycle", irq_o, 1);
    chk("R12 reloaded", count_o, 4);
    chk("R12 stopped", ctrl_o, 0);
    irqs = 0;
    for (int i = 0; i < 8; i++) begin step(1); if (irq_o) irqs++; end
    chk("R12 silent after stop", irqs, 0);
    chk("R12 counter held", count_o, 4);

    // R10 count source
    halt_and_load(16'h0010);
    wr(2'd2, 8'h21);
    step(7);
    chk("R10 pin source idle", count_o, 16'h0010);
    for (int i = 0; i < 3; i++) begin
      ext_cnt_i = 1'b1; step(1); ext_cnt_i = 1'b0; step(1);
    end
    chk("R10 pin strobes counted", count_o, 16'h000D);
    wr(2'd2, 8'h41);
    step(1);
    for (int i = 0; i < 2; i++) begin
      ext_cnt_i = 1'b1; step(1); ext_cnt_i = 1'b0; step(1);
    end
    chk("R10 pin ignored in cascade mode", count_o, 16'h000D);
    for (int i = 0; i < 3; i++) begin
      cascade_i = 1'b1; step(1); cascade_i = 1'b0; step(1);
    end
    chk("R10 cascade strobes counted", count_o, 16'h000A);

    // R11 tick enable
    wr(2'd2, 8'h01);
    step(2);
    tick_i = 1'b0;
    x = count_o;
    step(5);
    chk("R11 counter holds", count_o, x);
    wr(2'd2, 8'h00);
    tick_i = 1'b1;
    step(3);
    chk("R11 write ignored, still counting", count_o, x - 3);
    chk("R11 ctrl unchanged", ctrl_o, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule